// File: doc/BRIEF.md
# SPI command decoder register bank

This block is an SPI target placed between a host microcontroller and on-chip logic. Each chip-select frame starts with one opcode byte. The high nibble of the opcode selects the command. The low nibble carries operands such as the memory target, the auto-increment flag or the mapper code. The bytes that follow in the same frame are parameters. From these frames the block drives a simple byte-wide memory strobe interface. It also holds a handful of configuration registers: the mapper code, the feature-enable byte, the memory-bank select and an 8-bit status register that is changed through separate set and clear masks.

Commands that return data put their answer on MISO starting in the second byte slot after the opcode, so the host always clocks one dummy byte first. The SPI pins are sampled by the system clock through synchronizers. Serial data follows SPI mode 0: the clock idles low, the target samples on the rising edge and shifts on the falling edge, most significant bit first. When chip select goes high, any partial command is dropped.

Top module: `spi_cmd_regbank`

## Requirements
- R1: Opcode 0x00 loads the target-0 address from the next three bytes, most significant first. Opcodes 0x01 and 0x02 load the 16-bit address of target 1 or 2 from the next two bytes and clear the upper address byte. Each target keeps its own address, and the address changes only when its last byte arrives.
- R2: Opcode 0x9p writes every following byte to the memory of target p[1:0] (0 to 2), with p[2]=0. Each byte gives one mem_we pulse that carries mem_addr, mem_tgt and mem_wdata. When p[3]=1 the address of that target steps by one after each byte. mem_we and mem_re are never high together.
- R3: Opcode 0x88 or 0x80 reads target 0. From the end of the dummy byte onward, the byte read at the current address is returned in the next slot. 0x88 steps the address once per byte after the opcode, and 0x80 leaves it unchanged.
- R4: Opcode 0x3m stores m as the mapper code only when m is 0, 1, 2, 6 or 7. Any other m leaves the mapper code unchanged.
- R5: Opcode 0xE0 takes a set mask and then a clear mask. The status register becomes (old | set) & ~clear, so a bit named in both masks ends up cleared. It changes only when the clear mask arrives.
- R6: Opcode 0xF1 returns the 16-bit status word, high byte in slot 2 and low byte in slot 3. The bits are: bit 15 = dma_busy, bit 5 = req_audio, bit 4 = req_data, bits 2:0 = status register bits 2:0. All other bits are 0.
- R7: Opcode 0xED loads the next byte into feature_en. Opcode 0xEE sets mem_bank_sel to 0 or 1 when the next byte is 0x00 or 0x01 and ignores any other value. Outside these commands feature_en does not change.
- R8: Opcode 0xF0 returns the token 0xA5 in slot 2. Slots 0 and 1 of every frame return 0x00.
- R9: Opcode 0xFF echoes each byte received after the opcode in the byte slot that follows it.
- R10: Raising chip select drops a partial command: no address or status update takes effect, and the next frame's first byte is decoded as an opcode. MISO is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| dma_busy | input | 1 | Busy flag reported in status word bit 15 |
| req_audio | input | 1 | Request flag reported in status word bit 5 |
| req_data | input | 1 | Request flag reported in status word bit 4 |
| mem_addr | output | 24 | Address of the current memory access |
| mem_tgt | output | 2 | Target of the current memory access |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read strobe |
| mem_rdata | input | 8 | Read data, combinational from mem_addr |
| mapper_code | output | 4 | Mapper code register |
| feature_en | output | 8 | Feature-enable register |
| mem_bank_sel | output | 1 | Memory bank select |
| status_bits | output | 8 | Status register |

## Verification
A wrong opcode latch or byte counter shows up in the same frame as a misplaced mem_we pulse or as a reply shifted by one slot on MISO. The error is visible within one byte time, about 128 clock cycles. A faulty address register does not show when it is loaded. It shows on mem_addr at the next write frame to that target, so every address load is followed by a write that exposes it. A wrong set/clear merge or a wrong register-select decode appears on status_bits, mapper_code, feature_en or mem_bank_sel within a few cycles of the byte that caused it. A chip-select abort that leaks through shows up as a wrong address in the write frame that follows it.

// File: rtl/spi_cmd_pkg.sv
// Package: shared constants and helpers for the SPI command register bank.
// Assumes: opcodes are one byte, high nibble = command class.
package spi_cmd_pkg;
    localparam logic [3:0] CLS_ADDR  = 4'h0;
    localparam logic [3:0] CLS_MAP   = 4'h3;
    localparam logic [3:0] CLS_READ  = 4'h8;
    localparam logic [3:0] CLS_WRITE = 4'h9;
    localparam logic [7:0] OP_STAT_SET = 8'hE0;
    localparam logic [7:0] OP_FEATURE  = 8'hED;
    localparam logic [7:0] OP_BANK     = 8'hEE;
    localparam logic [7:0] OP_TOKEN    = 8'hF0;
    localparam logic [7:0] OP_STATUS   = 8'hF1;
    localparam logic [7:0] OP_ECHO     = 8'hFF;

    // Mapper codes the block accepts.
    function automatic logic mapper_ok(input logic [3:0] m);
        return (m == 4'd0) || (m == 4'd1) || (m == 4'd2) || (m == 4'd6) || (m == 4'd7);
    endfunction
endpackage

// File: rtl/spi_byte_shifter.sv
// Module: spi_byte_shifter
// Synchronizes the SPI pins into clk and assembles mode-0 bytes, MSB first.
// Assumes sclk is slower than clk/4 and idles low. tx_byte is loaded into the
// output shifter on the falling edge that ends each byte.
module spi_byte_shifter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       frame_active,
    output logic       rx_valid,
    output logic [7:0] rx_byte
);
    logic [SYNC_STAGES-1:0] sclk_sr, cs_sr, mosi_sr;
    logic       sclk_s, cs_s, mosi_s, sclk_d;
    logic [2:0] bit_cnt;
    logic [7:0] rx_sr, tx_sr;
    logic       rise, fall;

    // Bring the SPI pins into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_sr <= '0;
            cs_sr   <= '1;
            mosi_sr <= '0;
            sclk_d  <= 1'b0;
        end else begin
            sclk_sr <= {sclk_sr[SYNC_STAGES-2:0], sclk};
            cs_sr   <= {cs_sr[SYNC_STAGES-2:0], cs_n};
            mosi_sr <= {mosi_sr[SYNC_STAGES-2:0], mosi};
            sclk_d  <= sclk_s;
        end
    end

    assign sclk_s = sclk_sr[SYNC_STAGES-1];
    assign cs_s   = cs_sr[SYNC_STAGES-1];
    assign mosi_s = mosi_sr[SYNC_STAGES-1];
    assign rise   = sclk_s & ~sclk_d;
    assign fall   = ~sclk_s & sclk_d;

    // Shift bits in on rising edges and out on falling edges, inside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (rise) begin
                rx_sr   <= {rx_sr[6:0], mosi_s};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= {rx_sr[6:0], mosi_s};
                end
            end
            if (fall) begin
                tx_sr <= (bit_cnt == 3'd0) ? tx_byte : {tx_sr[6:0], 1'b0};
            end
        end
    end

    assign miso         = tx_sr[7];
    assign frame_active = ~cs_s;
endmodule

// File: rtl/spi_cfg_regs.sv
// Module: spi_cfg_regs
// Holds the mapper code, feature-enable byte, bank select and status register.
// Assumes the write strobes are single-cycle pulses from the command decoder.
module spi_cfg_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       map_we,
    input  logic [3:0] map_val,
    input  logic       feat_we,
    input  logic       bank_we,
    input  logic       stat_we,
    input  logic [7:0] stat_set,
    input  logic [7:0] wr_val,
    output logic [3:0] mapper_code,
    output logic [7:0] feature_en,
    output logic       bank_sel,
    output logic [7:0] status_q
);
    import spi_cmd_pkg::*;

    // Apply the configuration strobes; illegal values are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mapper_code <= '0;
            feature_en  <= '0;
            bank_sel    <= 1'b0;
            status_q    <= '0;
        end else begin
            if (map_we && mapper_ok(map_val)) mapper_code <= map_val;
            if (feat_we) feature_en <= wr_val;
            if (bank_we && (wr_val[7:1] == 7'd0)) bank_sel <= wr_val[0];
            if (stat_we) status_q <= (status_q | stat_set) & ~wr_val;
        end
    end
endmodule

// File: rtl/spi_cmd_decoder.sv
// Module: spi_cmd_decoder
// Counts bytes in a frame, latches the opcode and turns parameter bytes into
// address loads, memory strobes, config strobes and reply bytes.
// Assumes mem_rdata is valid in the same cycle as mem_addr.
module spi_cmd_decoder #(
    parameter int    ADDR_W  = 24,
    parameter int    NUM_TGT = 3,
    parameter int    IDX_W   = 3,
    parameter logic [7:0] TOKEN = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_active,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              dma_busy,
    input  logic              req_audio,
    input  logic              req_data,
    input  logic [2:0]        stat_low,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        tx_byte,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_tgt,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic              map_we,
    output logic              feat_we,
    output logic              bank_we,
    output logic              stat_we,
    output logic [7:0]        stat_set
);
    import spi_cmd_pkg::*;

    localparam int ADDR_BYTES  = ADDR_W / 8;
    localparam int SHORT_BYTES = 2;
    localparam int SH_W        = ADDR_W - 8;
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic [IDX_W-1:0]  idx_q;
    logic [7:0]        op_q, snap_q, tx_next;
    logic [SH_W-1:0]   sh_q;
    logic [ADDR_W-1:0] addr_q [NUM_TGT];
    logic [3:0]        op_hi, op_lo;
    logic              first, beat, is_addr, is_rd, is_wr, load_hit, step;
    logic [1:0]        cur_tgt;
    logic [IDX_W-1:0]  last_idx;
    logic [15:0]       status_word;

    assign op_hi    = op_q[7:4];
    assign op_lo    = op_q[3:0];
    assign first    = (idx_q == '0);
    assign beat     = rx_valid && !first;
    assign is_addr  = (op_hi == CLS_ADDR) && (op_lo < 4'(NUM_TGT));
    assign is_rd    = (op_hi == CLS_READ) && (op_lo[2:0] == 3'd0);
    assign is_wr    = (op_hi == CLS_WRITE) && !op_lo[2] && ({2'b00, op_lo[1:0]} < 4'(NUM_TGT));
    assign cur_tgt  = is_wr ? op_lo[1:0] : 2'd0;
    assign last_idx = (op_lo == 4'd0) ? IDX_W'(ADDR_BYTES) : IDX_W'(SHORT_BYTES);
    assign load_hit = beat && is_addr && (idx_q == last_idx);
    assign status_word = {dma_busy, 9'd0, req_audio, req_data, 1'b0, stat_low};

    assign mem_we    = beat && is_wr;
    assign mem_re    = beat && is_rd;
    assign mem_wdata = rx_byte;
    assign mem_tgt   = cur_tgt;
    assign mem_addr  = addr_q[cur_tgt];
    assign step      = (mem_we || mem_re) && op_lo[3];

    assign map_we  = rx_valid && first && (rx_byte[7:4] == CLS_MAP);
    assign feat_we = beat && (op_q == OP_FEATURE)  && (idx_q == IDX_W'(1));
    assign bank_we = beat && (op_q == OP_BANK)     && (idx_q == IDX_W'(1));
    assign stat_we = beat && (op_q == OP_STAT_SET) && (idx_q == IDX_W'(2));

    // Byte position within the frame and the latched opcode.
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_active) begin
            idx_q <= '0;
        end else if (rx_valid && idx_q != IDX_MAX) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Opcode, address shadow, set mask and status snapshot registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= '0;
            sh_q     <= '0;
            stat_set <= '0;
            snap_q   <= '0;
        end else if (rx_valid) begin
            if (first) op_q <= rx_byte;
            if (beat && is_addr) sh_q <= (idx_q == IDX_W'(1)) ? SH_W'(rx_byte) : {sh_q[SH_W-9:0], rx_byte};
            if (beat && op_q == OP_STAT_SET && idx_q == IDX_W'(1)) stat_set <= rx_byte;
            if (beat && op_q == OP_STATUS && idx_q == IDX_W'(1)) snap_q <= status_word[7:0];
        end
    end

    // One address register per target: load on the final byte, else step.
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_addr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q[t] <= '0;
            end else if (load_hit && op_lo[1:0] == 2'(t)) begin
                addr_q[t] <= {sh_q, rx_byte};
            end else if (step && cur_tgt == 2'(t)) begin
                addr_q[t] <= addr_q[t] + 1'b1;
            end
        end
    end

    // Choose the byte for the next slot.
    always_comb begin
        tx_next = 8'h00;
        if (!first) begin
            if (is_rd) tx_next = mem_rdata;
            else if (op_q == OP_TOKEN && idx_q == IDX_W'(1)) tx_next = TOKEN;
            else if (op_q == OP_STATUS && idx_q == IDX_W'(1)) tx_next = status_word[15:8];
            else if (op_q == OP_STATUS && idx_q == IDX_W'(2)) tx_next = snap_q;
            else if (op_q == OP_ECHO) tx_next = rx_byte;
        end
    end

    // Reply register handed to the shifter at each byte end.
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_active) tx_byte <= '0;
        else if (rx_valid) tx_byte <= tx_next;
    end
endmodule

// File: rtl/spi_cmd_regbank.sv
// Module: spi_cmd_regbank (top)
// SPI command target: byte shifter, command decoder and config registers.
// Assumes a synchronous active-low reset and SPI mode 0 pins driven slowly
// relative to clk.
module spi_cmd_regbank #(
    parameter int ADDR_W      = 24,
    parameter int NUM_TGT     = 3,
    parameter int IDX_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              dma_busy,
    input  logic              req_audio,
    input  logic              req_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_tgt,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata,
    output logic [3:0]        mapper_code,
    output logic [7:0]        feature_en,
    output logic              mem_bank_sel,
    output logic [7:0]        status_bits
);
    logic       frame_active, rx_valid;
    logic [7:0] rx_byte, tx_byte, stat_set;
    logic       map_we, feat_we, bank_we, stat_we;

    spi_byte_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .tx_byte(tx_byte), .miso(spi_miso), .frame_active(frame_active),
        .rx_valid(rx_valid), .rx_byte(rx_byte)
    );

    spi_cmd_decoder #(.ADDR_W(ADDR_W), .NUM_TGT(NUM_TGT), .IDX_W(IDX_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .frame_active(frame_active), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .dma_busy(dma_busy), .req_audio(req_audio), .req_data(req_data),
        .stat_low(status_bits[2:0]), .mem_rdata(mem_rdata), .tx_byte(tx_byte),
        .mem_addr(mem_addr), .mem_tgt(mem_tgt), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .map_we(map_we), .feat_we(feat_we), .bank_we(bank_we),
        .stat_we(stat_we), .stat_set(stat_set)
    );

    spi_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_val(rx_byte[3:0]),
        .feat_we(feat_we), .bank_we(bank_we), .stat_we(stat_we), .stat_set(stat_set),
        .wr_val(rx_byte), .mapper_code(mapper_code), .feature_en(feature_en),
        .bank_sel(mem_bank_sel), .status_q(status_bits)
    );
endmodule

// File: rtl/spi_cmd_regbank_chk.sv
// Module: spi_cmd_regbank_chk
// Assertion checker bound to spi_cmd_regbank; observes ports and byte strobe.
module spi_cmd_regbank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       spi_miso,
    input logic       mem_we,
    input logic       mem_re,
    input logic       rx_valid,
    input logic [3:0] mapper_code,
    input logic [7:0] feature_en
);
    // R2: write and read strobes are exclusive.
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R4: the mapper code only ever holds an accepted value.
    p_mapper_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mapper_code == 4'd0) || (mapper_code == 4'd1) || (mapper_code == 4'd2) ||
        (mapper_code == 4'd6) || (mapper_code == 4'd7));

    // R7: feature_en changes only after a received byte.
    p_feature_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(feature_en));

    // R10: MISO stays low once chip select has been high for a while.
    p_miso_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3) && $past(spi_cs_n, 4))
        |-> !spi_miso);
endmodule

bind spi_cmd_regbank spi_cmd_regbank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
    .mem_we(mem_we), .mem_re(mem_re), .rx_valid(rx_valid),
    .mapper_code(mapper_code), .feature_en(feature_en)
);

// File: tb/spi_cmd_regbank_bench.sv
module spi_cmd_regbank_bench;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic dma_busy = 1'b0, req_audio = 1'b0, req_data = 1'b0;
    logic [23:0] mem_addr;
    logic [1:0]  mem_tgt;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_we, mem_re;
    logic [3:0]  mapper_code;
    logic [7:0]  feature_en, status_bits;
    logic        mem_bank_sel;

    int total = 0, bad = 0;
    logic [7:0] txb [8];
    logic [7:0] rxb [8];

    logic [23:0] wl_addr [64];
    logic [7:0]  wl_data [64];
    logic [1:0]  wl_tgt  [64];
    int wr_total = 0;

    always #4 clk = ~clk;

    spi_cmd_regbank u_spi_cmd_regbank (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .dma_busy(dma_busy), .req_audio(req_audio), .req_data(req_data),
        .mem_addr(mem_addr), .mem_tgt(mem_tgt), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata), .mapper_code(mapper_code),
        .feature_en(feature_en), .mem_bank_sel(mem_bank_sel), .status_bits(status_bits)
    );

    // Memory model: read data is a fixed function of the address.
    assign mem_rdata = mem_addr[7:0] + 8'h11;

    always @(posedge clk) begin
        if (mem_we) begin
            wl_addr[wr_total % 64] <= mem_addr;
            wl_data[wr_total % 64] <= mem_wdata;
            wl_tgt[wr_total % 64]  <= mem_tgt;
            wr_total <= wr_total + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tb, output logic [7:0] rb);
        for (int i = 7; i >= 0; i--) begin
            mosi = tb[i];
            repeat (HALF) @(negedge clk);
            rb[i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic frame(input int n);
        logic [7:0] r;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            xfer(txb[k], r);
            rxb[k] = r;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic send(input int n, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] b2, input logic [7:0] b3);
        txb[0] = b0; txb[1] = b1; txb[2] = b2; txb[3] = b3;
        frame(n);
    endtask

    task automatic chk_wr(input string req, input int base, input int k,
                          input logic [23:0] a, input logic [7:0] d, input logic [1:0] t);
        chk({req, " addr"}, 32'(wl_addr[(base + k) % 64]), 32'(a));
        chk({req, " data"}, 32'(wl_data[(base + k) % 64]), 32'(d));
        chk({req, " tgt"},  32'(wl_tgt[(base + k) % 64]),  32'(t));
    endtask

    // {opcode, argument, expected mapper, expected feature, expected bank}
    localparam logic [28:0] CFG_VEC [10] = '{
        {8'h31, 8'h00, 4'h1, 8'h00, 1'b0},
        {8'h36, 8'h00, 4'h6, 8'h00, 1'b0},
        {8'h35, 8'h00, 4'h6, 8'h00, 1'b0},
        {8'h3F, 8'h00, 4'h6, 8'h00, 1'b0},
        {8'h32, 8'h00, 4'h2, 8'h00, 1'b0},
        {8'hED, 8'h5A, 4'h2, 8'h5A, 1'b0},
        {8'hED, 8'hC3, 4'h2, 8'hC3, 1'b0},
        {8'hEE, 8'h01, 4'h2, 8'hC3, 1'b1},
        {8'hEE, 8'h02, 4'h2, 8'hC3, 1'b1},
        {8'hEE, 8'h00, 4'h2, 8'hC3, 1'b0}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int base;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Reset state
        chk("R4 reset mapper", 32'(mapper_code), 0);
        chk("R7 reset feature", 32'(feature_en), 0);
        chk("R7 reset bank", 32'(mem_bank_sel), 0);
        chk("R5 reset status", 32'(status_bits), 0);
        chk("R10 reset miso", 32'(miso), 0);
        chk("R2 reset we", 32'(mem_we), 0);

        // Table walk: mapper, feature and bank select (R4, R7)
        for (int v = 0; v < 10; v++) begin
            send(2, CFG_VEC[v][28:21], CFG_VEC[v][20:13], 8'h00, 8'h00);
            chk($sformatf("R4 vec%0d mapper", v), 32'(mapper_code), 32'(CFG_VEC[v][12:9]));
            chk($sformatf("R7 vec%0d feature", v), 32'(feature_en), 32'(CFG_VEC[v][8:1]));
            chk($sformatf("R7 vec%0d bank", v), 32'(mem_bank_sel), 32'(CFG_VEC[v][0]));
        end

        // R1 + R2: three-byte address, incrementing write
        send(4, 8'h00, 8'h12, 8'h34, 8'h56);
        base = wr_total;
        send(3, 8'h98, 8'hAA, 8'hBB, 8'h00);
        chk("R2 inc write count", 32'(wr_total - base), 2);
        chk_wr("R1 R2 first write", base, 0, 24'h123456, 8'hAA, 2'd0);
        chk_wr("R2 second write", base, 1, 24'h123457, 8'hBB, 2'd0);

        // R2: non-incrementing write stays on one address
        base = wr_total;
        send(3, 8'h90, 8'h11, 8'h22, 8'h00);
        chk_wr("R2 hold write a", base, 0, 24'h123458, 8'h11, 2'd0);
        chk_wr("R2 hold write b", base, 1, 24'h123458, 8'h22, 2'd0);

        // R1: two-byte targets, independent registers
        send(3, 8'h01, 8'hAB, 8'hCD, 8'h00);
        base = wr_total;
        send(2, 8'h91, 8'h77, 8'h00, 8'h00);
        chk_wr("R1 target1", base, 0, 24'h00ABCD, 8'h77, 2'd1);
        base = wr_total;
        send(2, 8'h92, 8'h55, 8'h00, 8'h00);
        chk_wr("R1 target2 untouched", base, 0, 24'h000000, 8'h55, 2'd2);

        // R3: incrementing read with dummy byte
        send(4, 8'h00, 8'h00, 8'h00, 8'h40);
        send(4, 8'h88, 8'h00, 8'h00, 8'h00);
        chk("R8 slot0 zero", 32'(rxb[0]), 0);
        chk("R3 dummy slot", 32'(rxb[1]), 0);
        chk("R3 inc read0", 32'(rxb[2]), 32'h51);
        chk("R3 inc read1", 32'(rxb[3]), 32'h52);
        base = wr_total;
        send(2, 8'h90, 8'hEE, 8'h00, 8'h00);
        chk_wr("R3 addr after inc read", base, 0, 24'h000043, 8'hEE, 2'd0);

        // R3: non-incrementing read
        send(4, 8'h00, 8'h00, 8'h00, 8'h40);
        send(4, 8'h80, 8'h00, 8'h00, 8'h00);
        chk("R3 hold read0", 32'(rxb[2]), 32'h51);
        chk("R3 hold read1", 32'(rxb[3]), 32'h51);
        base = wr_total;
        send(2, 8'h90, 8'hEE, 8'h00, 8'h00);
        chk_wr("R3 addr after hold read", base, 0, 24'h000040, 8'hEE, 2'd0);

        // R10: aborted address loads leave registers alone
        send(3, 8'h00, 8'h77, 8'h66, 8'h00);
        send(2, 8'h01, 8'h99, 8'h00, 8'h00);
        base = wr_total;
        send(2, 8'h90, 8'hEE, 8'h00, 8'h00);
        chk_wr("R10 abort target0", base, 0, 24'h000040, 8'hEE, 2'd0);
        base = wr_total;
        send(2, 8'h91, 8'h33, 8'h00, 8'h00);
        chk_wr("R10 abort target1", base, 0, 24'h00ABCD, 8'h33, 2'd1);

        // R5: set/clear masks
        send(3, 8'hE0, 8'h07, 8'h00, 8'h00);
        chk("R5 set", 32'(status_bits), 32'h07);
        send(3, 8'hE0, 8'hF0, 8'h02, 8'h00);
        chk("R5 set and clear", 32'(status_bits), 32'hF5);
        send(3, 8'hE0, 8'h08, 8'h08, 8'h00);
        chk("R5 clear wins", 32'(status_bits), 32'hF5);

        // R10: aborted status command, next frame decodes a fresh opcode
        send(2, 8'hE0, 8'h05, 8'h00, 8'h00);
        chk("R10 abort status", 32'(status_bits), 32'hF5);
        send(2, 8'hED, 8'h3C, 8'h00, 8'h00);
        chk("R10 fresh opcode", 32'(feature_en), 32'h3C);

        // R6: status word
        dma_busy = 1'b1; req_audio = 1'b1; req_data = 1'b0;
        send(4, 8'hF1, 8'h00, 8'h00, 8'h00);
        chk("R6 dummy slot", 32'(rxb[1]), 0);
        chk("R6 high byte a", 32'(rxb[2]), 32'h80);
        chk("R6 low byte a", 32'(rxb[3]), 32'h25);
        dma_busy = 1'b0; req_audio = 1'b0; req_data = 1'b1;
        send(4, 8'hF1, 8'h00, 8'h00, 8'h00);
        chk("R6 high byte b", 32'(rxb[2]), 32'h00);
        chk("R6 low byte b", 32'(rxb[3]), 32'h15);

        // R8: test token
        send(3, 8'hF0, 8'h00, 8'h00, 8'h00);
        chk("R8 dummy slot", 32'(rxb[1]), 0);
        chk("R8 token", 32'(rxb[2]), 32'hA5);

        // R9: echo
        send(4, 8'hFF, 8'h11, 8'h22, 8'h33);
        chk("R9 echo slot1", 32'(rxb[1]), 0);
        chk("R9 echo a", 32'(rxb[2]), 32'h11);
        chk("R9 echo b", 32'(rxb[3]), 32'h22);

        // R10: idle MISO
        chk("R10 idle miso", 32'(miso), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule